// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block lets a processor core use its 14-bit-wide program memory as a source of constant tables. It holds an 8-bit table pointer and a read-only table-high register. Both sit on a small register bus with a combinational read path. The core issues table-read commands of two kinds. A current-page read takes its page from the upper bits of the program counter. A last-page read forces every page bit to one. In both cases the pointer supplies the word offset inside a 256-word page.

For each command the block forms the full program-memory address and drives it to a synchronous memory port. One cycle later it sends the low byte of the returned word to a data-memory write port. In that same cycle it captures the six upper bits of the word into the table-high register, which reads back with its top two bits at zero. The address width is a parameter: 10 bits for the smaller memory and 11 bits for the larger one. The number of page bits follows from it.

Top module: `tblrd_unit`

## Requirements
- R1: A page holds 256 words: `rom_addr[7:0]` always equals the table pointer value during a command cycle.
- R2: For a current-page read (`cmd_last_page`=0), `rom_addr` bits above bit 7 equal `cmd_page`.
- R3: For a last-page read (`cmd_last_page`=1), every `rom_addr` bit above bit 7 is 1.
- R4: In the cycle after a command, `dm_we`=1, `dm_addr` equals that command's `cmd_dst`, and `dm_wdata` equals bits 7:0 of the fetched word.
- R5: The table-high register, read at register address 8'h08, returns {2'b00, word[13:8]} of the most recent fetched word.
- R6: The table pointer is written and read back at register address 8'h07; a write takes effect at the clock edge and is visible on `reg_rdata` in the next cycle.
- R7: Bus writes to address 8'h08 leave the table-high register unchanged; reads of any address other than 8'h07 or 8'h08 return 8'h00.
- R8: A read takes two cycles: `rom_en` and `rom_addr` are valid in the command cycle, and the data-memory write happens in the following cycle. Table-high is readable one cycle after that write. `dm_we` is 0 in any cycle not preceded by a command.
- R9: The table-high register keeps its value until the next table read of either kind replaces it; back-to-back reads each update it in turn.
- R10: While `rst_n` is low at a clock edge, the pointer and the table-high register clear to zero and no data-memory write is pending.
- R11: With `ADDR_W`=10 the page field is 2 bits wide, so a last-page read addresses 10'h300 plus the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data (combinational) |
| cmd_valid | input | 1 | Table-read command strobe, one cycle per read |
| cmd_last_page | input | 1 | 1 = last page, 0 = current page |
| cmd_page | input | ADDR_W-8 | Page bits of the current program counter |
| cmd_dst | input | 8 | Data-memory address for the low byte |
| rom_en | output | 1 | Program-memory read enable |
| rom_addr | output | ADDR_W | Program-memory address |
| rom_data | input | 14 | Program-memory word, valid one cycle after `rom_en` |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data |

## Verification
The memory address is combinational and is checked just after the inputs change in the command cycle. The data-memory write is due one clock edge later. The table-high readback is due one edge after that, so each check waits for the matching falling edge. Pointer writes are read back one cycle after their edge. In the back-to-back case, the table-high value is sampled between the two updates, so each command's result is seen in its own cycle.

// File: rtl/tblrd_pkg.sv
// Package: shared constants and the page-select type for the table read unit.
// Assumes one page is 2**8 words and the register bus is byte wide.
package tblrd_pkg;

    // Page selection carried by a table-read command.
    typedef enum logic {
        PAGE_CURRENT = 1'b0,
        PAGE_LAST    = 1'b1
    } page_sel_e;

    // Default register bus map.
    localparam logic [7:0] REG_PTR_ADDR  = 8'h07;
    localparam logic [7:0] REG_HIGH_ADDR = 8'h08;

    // Default widths.
    localparam int unsigned OFFSET_W = 8;
    localparam int unsigned WORD_W   = 14;

endpackage

// File: rtl/tblrd_addr_gen.sv
// Module: tblrd_addr_gen
// Forms the program-memory address of a table read from the page choice,
// the program counter page bits and the table pointer.
// Assumes ADDR_W > OFFSET_W, so at least one page bit exists.
module tblrd_addr_gen
    import tblrd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned OFFSET_W = 8
) (
    input  page_sel_e                    sel,
    input  logic [ADDR_W-OFFSET_W-1:0]   pc_page,
    input  logic [OFFSET_W-1:0]          offset,
    output logic [ADDR_W-1:0]            addr
);
    localparam int unsigned PAGE_W = ADDR_W - OFFSET_W;
    localparam logic [PAGE_W-1:0] LAST_PAGE = {PAGE_W{1'b1}};

    logic [PAGE_W-1:0] page;

    // Pick the page: the fixed top page or the one the program counter is in.
    always_comb begin
        if (sel == PAGE_LAST) page = LAST_PAGE;
        else                  page = pc_page;
    end

    // Join the page with the word offset inside it.
    always_comb addr = {page, offset};

endmodule

// File: rtl/tblrd_fetch.sv
// Module: tblrd_fetch
// Holds one table read for the cycle in which the synchronous memory returns
// its word. It then issues the data-memory write of the low bits and hands the
// high bits to the register file. Accepts a new command every cycle.
// Assumes the memory word is valid exactly one cycle after the read enable.
module tblrd_fetch #(
    parameter int unsigned WORD_W = 14,
    parameter int unsigned LOW_W  = 8,
    parameter int unsigned DST_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [DST_W-1:0]         cmd_dst,
    input  logic [WORD_W-1:0]        rom_data,
    output logic                     dm_we,
    output logic [DST_W-1:0]         dm_addr,
    output logic [LOW_W-1:0]         dm_wdata,
    output logic                     hi_load,
    output logic [WORD_W-LOW_W-1:0]  hi_bits
);
    logic             pend_q;
    logic [DST_W-1:0] dst_q;

    // Remember that a read is in flight and where its low byte goes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            dst_q  <= '0;
        end else begin
            pend_q <= cmd_valid;
            if (cmd_valid) dst_q <= cmd_dst;
        end
    end

    // Split the returned word between data memory and the table-high register.
    always_comb begin
        dm_we    = pend_q;
        dm_addr  = dst_q;
        dm_wdata = rom_data[LOW_W-1:0];
        hi_load  = pend_q;
        hi_bits  = rom_data[WORD_W-1:LOW_W];
    end

    // R8: every command yields a write in the next cycle.
    p_two_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> dm_we);

    // R8: no write without a command one cycle earlier.
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !dm_we);

    // R4: the write lands at the destination given with the command.
    p_dst_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (dm_addr == $past(cmd_dst)));

endmodule

// File: rtl/tblrd_regs.sv
// Module: tblrd_regs
// Register file of the unit: the read/write table pointer and the read-only
// table-high register, with a combinational read mux on the register bus.
// Assumes the bus width equals the pointer width and is wider than the high field.
module tblrd_regs #(
    parameter int unsigned     BUS_W     = 8,
    parameter int unsigned     HIGH_W    = 6,
    parameter int unsigned     RADDR_W   = 8,
    parameter logic [7:0]      PTR_ADDR  = 8'h07,
    parameter logic [7:0]      HIGH_ADDR = 8'h08
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    input  logic                 hi_load,
    input  logic [HIGH_W-1:0]    hi_bits,
    output logic [BUS_W-1:0]     ptr
);
    localparam int unsigned PAD_W = BUS_W - HIGH_W;

    logic [BUS_W-1:0]  ptr_q;
    logic [HIGH_W-1:0] high_q;
    logic [BUS_W-1:0]  high_view;
    logic              sel_ptr;
    logic              sel_high;

    // Decode the bus address.
    always_comb begin
        sel_ptr  = (addr == RADDR_W'(PTR_ADDR));
        sel_high = (addr == RADDR_W'(HIGH_ADDR));
    end

    // Table pointer: loaded only by bus writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr_q <= '0;
        else if (wr_en && sel_ptr) ptr_q <= wdata;
    end

    // Table-high: loaded only by completed table reads, never by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       high_q <= '0;
        else if (hi_load) high_q <= hi_bits;
    end

    // Zero-extend the high field to the bus width.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb high_view = {{PAD_W{1'b0}}, high_q};
        end else begin : g_nopad
            always_comb high_view = high_q[BUS_W-1:0];
        end
    endgenerate

    // Read mux; unmapped addresses return zero.
    always_comb begin
        if (sel_ptr)       rdata = ptr_q;
        else if (sel_high) rdata = high_view;
        else               rdata = '0;
    end

    always_comb ptr = ptr_q;

    // R6: a pointer write is held from the next cycle on.
    p_ptr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ptr) |=> (ptr_q == $past(wdata)));

    // R5: a completed read deposits its high bits.
    p_high_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> (high_q == $past(hi_bits)));

    // R7: bus writes aimed at table-high do not change it.
    p_high_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_high && !hi_load) |=> $stable(high_q));

    // R9: without a read the value is kept.
    p_high_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_load |=> $stable(high_q));

    // R5: the upper read-back bits of table-high are always zero.
    p_high_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_high |-> (rdata[BUS_W-1:HIGH_W] == '0));

endmodule

// File: rtl/tblrd_unit.sv
// Module: tblrd_unit (top)
// Table read unit: address formation, memory fetch and result distribution.
// Assumes a synchronous program memory with one cycle of read latency, and a
// data memory that accepts a write in any cycle.
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned OFFSET_W  = 8,
    parameter int unsigned WORD_W    = 14,
    parameter int unsigned DST_W     = 8,
    parameter logic [7:0]  PTR_ADDR  = REG_PTR_ADDR,
    parameter logic [7:0]  HIGH_ADDR = REG_HIGH_ADDR
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_en,
    input  logic [7:0]                  reg_addr,
    input  logic [OFFSET_W-1:0]         reg_wdata,
    output logic [OFFSET_W-1:0]         reg_rdata,
    input  logic                        cmd_valid,
    input  logic                        cmd_last_page,
    input  logic [ADDR_W-OFFSET_W-1:0]  cmd_page,
    input  logic [DST_W-1:0]            cmd_dst,
    output logic                        rom_en,
    output logic [ADDR_W-1:0]           rom_addr,
    input  logic [WORD_W-1:0]           rom_data,
    output logic                        dm_we,
    output logic [DST_W-1:0]            dm_addr,
    output logic [OFFSET_W-1:0]         dm_wdata
);
    localparam int unsigned HIGH_W = WORD_W - OFFSET_W;

    logic [OFFSET_W-1:0] ptr;
    logic                hi_load;
    logic [HIGH_W-1:0]   hi_bits;
    page_sel_e           sel;

    // Map the command bit onto the page-select type.
    always_comb sel = cmd_last_page ? PAGE_LAST : PAGE_CURRENT;

    tblrd_regs #(
        .BUS_W     (OFFSET_W),
        .HIGH_W    (HIGH_W),
        .RADDR_W   (8),
        .PTR_ADDR  (PTR_ADDR),
        .HIGH_ADDR (HIGH_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .hi_load (hi_load),
        .hi_bits (hi_bits),
        .ptr     (ptr)
    );

    tblrd_addr_gen #(
        .ADDR_W   (ADDR_W),
        .OFFSET_W (OFFSET_W)
    ) u_addr (
        .sel     (sel),
        .pc_page (cmd_page),
        .offset  (ptr),
        .addr    (rom_addr)
    );

    // The memory is read exactly in command cycles.
    always_comb rom_en = cmd_valid;

    tblrd_fetch #(
        .WORD_W (WORD_W),
        .LOW_W  (OFFSET_W),
        .DST_W  (DST_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_dst   (cmd_dst),
        .rom_data  (rom_data),
        .dm_we     (dm_we),
        .dm_addr   (dm_addr),
        .dm_wdata  (dm_wdata),
        .hi_load   (hi_load),
        .hi_bits   (hi_bits)
    );

    // R1: the offset on the memory port is the pointer that the bus reads back.
    p_offset_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && reg_addr == PTR_ADDR) |-> (rom_addr[OFFSET_W-1:0] == reg_rdata));

endmodule

// File: tb/tblrd_unit_tb.sv
module tblrd_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_last_page = 1'b0;
    logic [10:0] cmd_pc = '0;
    logic [7:0]  cmd_dst = 8'h00;
    logic        rom_en;
    logic [10:0] rom_addr;
    logic [13:0] rom_q = '0;
    logic        dm_we;
    logic [7:0]  dm_addr;
    logic [7:0]  dm_wdata;

    logic [7:0]  reg_rdata_n;
    logic        rom_en_n;
    logic [9:0]  rom_addr_n;
    logic [13:0] rom_q_n = '0;
    logic        dm_we_n;
    logic [7:0]  dm_addr_n;
    logic [7:0]  dm_wdata_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tblrd_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_last_page(cmd_last_page), .cmd_page(cmd_pc[10:8]), .cmd_dst(cmd_dst),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_q),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    tblrd_unit #(.ADDR_W(10)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata_n),
        .cmd_valid(cmd_valid), .cmd_last_page(cmd_last_page), .cmd_page(cmd_pc[9:8]), .cmd_dst(cmd_dst),
        .rom_en(rom_en_n), .rom_addr(rom_addr_n), .rom_data(rom_q_n),
        .dm_we(dm_we_n), .dm_addr(dm_addr_n), .dm_wdata(dm_wdata_n)
    );

    function automatic logic [13:0] rom_word(input logic [10:0] a);
        logic [10:0] m;
        m = 11'(a * 11'd97);
        return {3'b000, m} ^ {a[2:0], a} ^ 14'h2D3;
    endfunction

    // Behavioral synchronous program memory, one cycle of latency.
    always @(posedge clk) begin
        if (rom_en)   rom_q   <= rom_word(rom_addr);
        if (rom_en_n) rom_q_n <= rom_word({1'b0, rom_addr_n});
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Vector: {last_page, pc[10:0], pointer, destination}
    localparam int NVEC = 8;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 11'h0A3, 8'h10, 8'h20},
        {1'b0, 11'h1FF, 8'hFF, 8'h21},
        {1'b0, 11'h7FE, 8'h00, 8'h22},
        {1'b1, 11'h123, 8'h5A, 8'h23},
        {1'b1, 11'h000, 8'hFF, 8'h24},
        {1'b0, 11'h455, 8'h80, 8'h7F},
        {1'b1, 11'h7FF, 8'h00, 8'h80},
        {1'b0, 11'h300, 8'hC3, 8'hFF}
    };

    function automatic logic [10:0] exp_addr(input logic last, input logic [10:0] pc, input logic [7:0] p);
        return last ? {3'b111, p} : {pc[10:8], p};
    endfunction

    function automatic logic [9:0] exp_addr_n(input logic last, input logic [10:0] pc, input logic [7:0] p);
        return last ? {2'b11, p} : {pc[9:8], p};
    endfunction

    initial begin
        logic [7:0] rd;
        logic [13:0] w1, w2, w_prev;
        logic [10:0] a1, a2;

        // Reset state (R10)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_reg(8'h07, rd); chk("R10 pointer after reset", rd, 8'h00);
        read_reg(8'h08, rd); chk("R10 table-high after reset", rd, 8'h00);
        chk("R10 no write after reset", dm_we, 1'b0);

        // Main table walk (R1 R2 R3 R4 R5 R6 R8 R11)
        for (int i = 0; i < NVEC; i++) begin
            logic        last;
            logic [10:0] pc, ea;
            logic [7:0]  p, dst;
            logic [13:0] w;
            {last, pc, p, dst} = VEC[i];
            ea = exp_addr(last, pc, p);
            w  = rom_word(ea);
            write_reg(8'h07, p);
            read_reg(8'h07, rd); chk("R6 pointer readback", rd, p);
            cmd_valid = 1'b1; cmd_last_page = last; cmd_pc = pc; cmd_dst = dst;
            #1;
            chk("R8 rom_en in command cycle", rom_en, 1'b1);
            chk("R1 offset from pointer", rom_addr[7:0], p);
            if (last) chk("R3 last page bits", rom_addr[10:8], 3'b111);
            else      chk("R2 current page bits", rom_addr[10:8], pc[10:8]);
            chk("R11 narrow address", rom_addr_n, exp_addr_n(last, pc, p));
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            chk("R8 write one cycle later", dm_we, 1'b1);
            chk("R4 write address", dm_addr, dst);
            chk("R4 write data low byte", dm_wdata, w[7:0]);
            @(negedge clk);
            chk("R8 single write per read", dm_we, 1'b0);
            read_reg(8'h08, rd); chk("R5 table-high value", rd, {2'b00, w[13:8]});
        end

        // R7: writes to table-high ignored, unmapped reads zero
        read_reg(8'h08, rd);
        w_prev = {6'h00, rd};
        write_reg(8'h08, 8'hFF);
        read_reg(8'h08, rd); chk("R7 table-high write ignored", rd, w_prev[7:0]);
        write_reg(8'h09, 8'hAA);
        read_reg(8'h09, rd); chk("R7 unmapped reads zero", rd, 8'h00);

        // R9: value held over idle cycles
        repeat (5) @(negedge clk);
        read_reg(8'h08, rd); chk("R9 table-high held", rd, w_prev[7:0]);

        // R9: back-to-back reads, each replaces the previous result
        write_reg(8'h07, 8'h3C);
        a1 = {3'b010, 8'h3C}; a2 = {3'b111, 8'h3C};
        w1 = rom_word(a1); w2 = rom_word(a2);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_last_page = 1'b0; cmd_pc = 11'h2AA; cmd_dst = 8'h41;
        @(negedge clk);
        cmd_last_page = 1'b1; cmd_dst = 8'h42;
        #1;
        chk("R4 first back-to-back data", dm_wdata, w1[7:0]);
        chk("R3 second back-to-back address", rom_addr, a2);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R4 second back-to-back address", dm_addr, 8'h42);
        chk("R4 second back-to-back data", dm_wdata, w2[7:0]);
        read_reg(8'h08, rd); chk("R9 first result visible", rd, {2'b00, w1[13:8]});
        @(negedge clk);
        read_reg(8'h08, rd); chk("R9 second result replaces first", rd, {2'b00, w2[13:8]});

        // R10: reset during a read clears state and drops the pending write
        write_reg(8'h07, 8'h99);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_last_page = 1'b0; cmd_pc = 11'h100;
        @(negedge clk);
        cmd_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 pending write dropped", dm_we, 1'b0);
        read_reg(8'h07, rd); chk("R10 pointer cleared", rd, 8'h00);
        read_reg(8'h08, rd); chk("R10 table-high cleared", rd, 8'h00);

        done = 1'b1;
        summary();
    end

endmodule